// File: doc/BRIEF.md
# Bidirectional Cascadable Row-Scan Core

This block is the logic core of a row-scan driver for an active-matrix display. A single start pulse enters a chain of `N` stages on the rising edge of the scan clock and moves one stage per rising edge. The stage that holds the pulse selects its row output, and every other row output stays deselected. A direction input sets the end of the chain where the pulse enters. It also sets which of two bidirectional cascade pins receives the start pulse and which one passes the pulse on to the next driver in a chain of drivers.

The pulse leaves the chain through the stage at the far end. That stage is retimed on the falling clock edge, which gives the next driver half a period of setup before its own rising edge. Three mask inputs each force one interleaved third of the row outputs to the deselected level. The masking is combinational, so it acts at once and does not wait for a clock edge. Each bidirectional pin appears as a separate input, output and output-enable.

Top module: `scan_gate_core`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every stage is cleared. `row_sel` then reads all zero, and both cascade outputs read 0 from the next falling edge.
- R2: With `dir_fwd` = 1, `pin_a_in` is sampled on each rising edge into `row_sel[0]`, and the contents move from index i to index i+1 on every rising edge.
- R3: With `dir_fwd` = 0, `pin_b_in` is sampled on each rising edge into `row_sel[N-1]`, and the contents move from index i to index i-1 on every rising edge.
- R4: A single start pulse asserts each row output for exactly one clock period. After it passes the last stage, `row_sel` returns to all zero.
- R5: The cascade output is the last stage for the current direction (index N-1 when `dir_fwd` = 1, index 0 when `dir_fwd` = 0), captured on the falling edge. It is driven on `pin_b_out` when `dir_fwd` = 1 and on `pin_a_out` when `dir_fwd` = 0. It is high from the falling edge inside the period when that stage holds the pulse until the next falling edge.
- R6: `pin_b_oe` equals `dir_fwd` and `pin_a_oe` equals its inverse. The cascade-output pin's input is ignored: its value has no effect on `row_sel`.
- R7: `oe_mask[0]` governs the outputs with index mod 3 = 0 (0-based, output 1 first), `oe_mask[1]` governs those with index mod 3 = 1, and `oe_mask[2]` governs those with index mod 3 = 2. A high mask bit forces every output it governs to 0.
- R8: Masking is combinational and acts without a clock edge. It changes neither the stage contents nor the cascade output.
- R9: With the start input held low, N rising edges flush any contents, including several adjacent pulses, to all zero. Adjacent pulses move together without interacting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_fwd | input | 1 | 1: pulse enters at index 0 from pin A; 0: enters at index N-1 from pin B |
| oe_mask | input | PH (3) | Per-phase force-deselect, active high |
| pin_a_in | input | 1 | Cascade pin A, input side |
| pin_a_out | output | 1 | Cascade pin A, output side |
| pin_a_oe | output | 1 | Cascade pin A output enable |
| pin_b_in | input | 1 | Cascade pin B, input side |
| pin_b_out | output | 1 | Cascade pin B, output side |
| pin_b_oe | output | 1 | Cascade pin B output enable |
| row_sel | output | N (256) | Row select lines, 1 = selected |

## Verification
The assertions run on every cycle. They check that a sampled start pulse lands at the correct end stage, that exactly one cascade pin is enabled and that it follows the direction input, and that a set mask bit keeps its whole residue class low. They also check that the falling-edge cascade output follows the last stage, and that reset clears the rows. The bench covers what only whole scenarios can show. It walks a pulse through every stage in both directions under all eight mask combinations, and it times the cascade pulse to the half cycle. It also confirms that a mask toggled between edges acts at once, that the unused cascade pin is ignored, and that a burst of pulses flushes out completely.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int unsigned SCAN_STAGES = 256;
    localparam int unsigned SCAN_PHASES = 3;

    typedef enum logic {
        DIR_DOWN = 1'b0,   // pulse enters at the top index, leaves at index 0
        DIR_UP   = 1'b1    // pulse enters at index 0, leaves at the top index
    } scan_dir_e;

    typedef struct packed {
        logic a_out;
        logic a_oe;
        logic b_out;
        logic b_oe;
    } casc_pins_t;

    // Mask phase that governs a given 0-based row index.
    function automatic int unsigned phase_of(int unsigned idx, int unsigned phases);
        return idx % phases;
    endfunction

endpackage

// File: rtl/scan_shift_chain.sv
module scan_shift_chain #(
    parameter int unsigned N = scan_pkg::SCAN_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_up,
    input  logic         start_in,
    output logic [N-1:0] stages
);
    // Extended vector: start at both ends so each stage picks a neighbour
    // for either direction without special-casing the chain ends.
    logic [N+1:0] ext;
    assign ext = {start_in, stages, start_in};

    for (genvar i = 0; i < N; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stages[i] <= 1'b0;
            else if (dir_up)
                stages[i] <= ext[i];       // previous index (or start at i=0)
            else
                stages[i] <= ext[i + 2];   // next index (or start at i=N-1)
        end
    end

endmodule

// File: rtl/cascade_steer.sv
module cascade_steer
    import scan_pkg::*;
#(
    parameter int unsigned N = scan_pkg::SCAN_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_fwd,
    input  logic [N-1:0] stages,
    input  logic         pin_a_in,
    input  logic         pin_b_in,
    output logic         start_in,
    output casc_pins_t   pins
);
    scan_dir_e dir;
    logic      tail;
    logic      casc_q;

    assign dir      = scan_dir_e'(dir_fwd);
    assign start_in = (dir == DIR_UP) ? pin_a_in : pin_b_in;
    assign tail     = (dir == DIR_UP) ? stages[N-1] : stages[0];

    // Retime the exiting stage on the falling edge for the next device.
    always_ff @(negedge clk) begin
        if (rst)
            casc_q <= 1'b0;
        else
            casc_q <= tail;
    end

    always_comb begin
        pins.a_out = casc_q;
        pins.b_out = casc_q;
        pins.a_oe  = (dir == DIR_DOWN);
        pins.b_oe  = (dir == DIR_UP);
    end

endmodule

// File: rtl/phase_mask.sv
module phase_mask
    import scan_pkg::*;
#(
    parameter int unsigned N  = scan_pkg::SCAN_STAGES,
    parameter int unsigned PH = scan_pkg::SCAN_PHASES
) (
    input  logic [N-1:0]  stages,
    input  logic [PH-1:0] oe_mask,
    output logic [N-1:0]  row_sel
);
    for (genvar i = 0; i < N; i++) begin : g_row
        localparam int unsigned P = phase_of(i, PH);
        assign row_sel[i] = stages[i] & ~oe_mask[P];
    end

endmodule

// File: rtl/scan_gate_core.sv
module scan_gate_core
    import scan_pkg::*;
#(
    parameter int unsigned N  = scan_pkg::SCAN_STAGES,
    parameter int unsigned PH = scan_pkg::SCAN_PHASES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_fwd,
    input  logic [PH-1:0] oe_mask,
    input  logic          pin_a_in,
    output logic          pin_a_out,
    output logic          pin_a_oe,
    input  logic          pin_b_in,
    output logic          pin_b_out,
    output logic          pin_b_oe,
    output logic [N-1:0]  row_sel
);
    logic [N-1:0] stages;
    logic         start_in;
    casc_pins_t   pins;

    cascade_steer #(.N(N)) u_steer (
        .clk      (clk),
        .rst      (rst),
        .dir_fwd  (dir_fwd),
        .stages   (stages),
        .pin_a_in (pin_a_in),
        .pin_b_in (pin_b_in),
        .start_in (start_in),
        .pins     (pins)
    );

    scan_shift_chain #(.N(N)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .dir_up   (dir_fwd),
        .start_in (start_in),
        .stages   (stages)
    );

    phase_mask #(.N(N), .PH(PH)) u_mask (
        .stages   (stages),
        .oe_mask  (oe_mask),
        .row_sel  (row_sel)
    );

    assign pin_a_out = pins.a_out;
    assign pin_a_oe  = pins.a_oe;
    assign pin_b_out = pins.b_out;
    assign pin_b_oe  = pins.b_oe;

endmodule

// File: rtl/scan_gate_core_chk.sv
module scan_gate_core_chk #(
    parameter int unsigned N  = 256,
    parameter int unsigned PH = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          dir_fwd,
    input logic [PH-1:0] oe_mask,
    input logic          pin_a_in,
    input logic          pin_b_in,
    input logic          pin_a_out,
    input logic          pin_b_out,
    input logic          pin_a_oe,
    input logic          pin_b_oe,
    input logic [N-1:0]  row_sel
);
    localparam int unsigned TOP_PH = (N - 1) % PH;

    function automatic logic [N-1:0] group_bits(int unsigned k);
        logic [N-1:0] g;
        g = '0;
        for (int unsigned i = 0; i < N; i++)
            if (i % PH == k) g[i] = 1'b1;
        return g;
    endfunction

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (row_sel == '0));

    assert_fwd_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (dir_fwd && pin_a_in) |=> (row_sel[0] || oe_mask[0]));

    assert_rev_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (!dir_fwd && pin_b_in) |=> (row_sel[N-1] || oe_mask[TOP_PH]));

    assert_casc_fwd_R5: assert property (@(negedge clk) disable iff (rst)
        (dir_fwd && row_sel[N-1]) |=> pin_b_out);

    assert_casc_rev_R5: assert property (@(negedge clk) disable iff (rst)
        (!dir_fwd && row_sel[0]) |=> pin_a_out);

    assert_pin_roles_R6: assert property (@(posedge clk) disable iff (rst)
        (pin_a_oe != pin_b_oe) && (pin_b_oe == dir_fwd));

    for (genvar k = 0; k < PH; k++) begin : g_grp
        assert_mask_group_R7: assert property (@(posedge clk) disable iff (rst)
            oe_mask[k] |-> ((row_sel & group_bits(k)) == '0));
    end

endmodule

bind scan_gate_core scan_gate_core_chk #(.N(N), .PH(PH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dir_fwd   (dir_fwd),
    .oe_mask   (oe_mask),
    .pin_a_in  (pin_a_in),
    .pin_b_in  (pin_b_in),
    .pin_a_out (pin_a_out),
    .pin_b_out (pin_b_out),
    .pin_a_oe  (pin_a_oe),
    .pin_b_oe  (pin_b_oe),
    .row_sel   (row_sel)
);

// File: tb/sim_scan_gate_core.sv
`timescale 1ns/1ps
module sim_scan_gate_core;
    localparam int N  = 256;
    localparam int PH = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dir_fwd = 1'b1;
    logic [PH-1:0] oe_mask = '0;
    logic          pin_a_in = 1'b0;
    logic          pin_b_in = 1'b0;
    logic          pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;
    logic [N-1:0]  row_sel;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    scan_gate_core #(.N(N), .PH(PH)) u0 (
        .clk(clk), .rst(rst), .dir_fwd(dir_fwd), .oe_mask(oe_mask),
        .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
        .row_sel(row_sel)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_rows(input bit d, input logic [PH-1:0] m, input int j);
        logic [N-1:0] e;
        int p;
        e = '0;
        if (j >= 1 && j <= N) begin
            p = d ? (j - 1) : (N - j);
            if (!m[p % PH]) e[p] = 1'b1;
        end
        return e;
    endfunction

    // One pulse through all stages; the idle cascade pin is held high (ignored).
    task automatic walk(input bit d, input logic [PH-1:0] m);
        @(posedge clk); #2;
        rst = 1'b1; dir_fwd = d; oe_mask = m; pin_a_in = 1'b0; pin_b_in = 1'b0;
        @(posedge clk); #2;
        rst = 1'b0; pin_a_in = 1'b1; pin_b_in = 1'b1;
        for (int j = 1; j <= N + 1; j++) begin
            @(posedge clk); #2;
            if (d) pin_a_in = 1'b0; else pin_b_in = 1'b0;
            chk(d ? "R2/R4/R6/R7 fwd row" : "R3/R4/R6/R7 rev row",
                row_sel, exp_rows(d, m, j));
            chk("R6 oe roles", {pin_a_oe, pin_b_oe}, {~d, d});
            if (m == '0 && j <= N) begin
                oe_mask = '1; #1;
                chk("R8 mask acts without clock", row_sel, '0);
                oe_mask = m; #1;
                chk("R8 mask release keeps stage", row_sel, exp_rows(d, m, j));
            end
            @(negedge clk); #2;
            chk(d ? "R5 cascade on pin_b_out" : "R5 cascade on pin_a_out",
                d ? pin_b_out : pin_a_out, (j == N));
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2;
        chk("R1 reset rows", row_sel, '0);
        chk("R1 reset cascade", {pin_a_out, pin_b_out}, 2'b00);
        chk("R6 reset oe", {pin_a_oe, pin_b_oe}, 2'b01);

        for (int m = 0; m < 8; m++) begin
            walk(1'b1, m[PH-1:0]);
            walk(1'b0, m[PH-1:0]);
        end

        // R9: burst of three pulses, then flush
        @(posedge clk); #2;
        rst = 1'b1; dir_fwd = 1'b1; oe_mask = '0; pin_a_in = 1'b0; pin_b_in = 1'b0;
        @(posedge clk); #2;
        rst = 1'b0; pin_a_in = 1'b1;
        repeat (3) @(posedge clk);
        #2; pin_a_in = 1'b0;
        chk("R9 burst loaded", row_sel, {{(N-3){1'b0}}, 3'b111});
        repeat (10) @(posedge clk);
        #2;
        chk("R9 burst moved", row_sel, {{(N-13){1'b0}}, 3'b111, 10'b0});
        repeat (N) @(posedge clk);
        #2;
        chk("R9 flushed", row_sel, '0);

        // R1: reset mid-scan clears the rows
        pin_a_in = 1'b1;
        @(posedge clk); #2;
        pin_a_in = 1'b0; rst = 1'b1;
        @(posedge clk); #2;
        chk("R1 mid-scan reset", row_sel, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule